// File: doc/BRIEF.md
# Prescaled Periodic Compare Timer

This block is a timer peripheral behind a plain 32-bit register port. A prescale counter runs on the block clock and is compared with a programmable limit. Each time the two are equal the prescale counter restarts and a 32-bit free-running counter advances by one. The free-running counter therefore steps once every (limit + 1) clocks while counting is enabled.

A compare register watches the free-running counter. When an advance brings the counter onto the compare value, interrupt flag bit 0 is raised. In the same cycle a programmable step value is added to the compare register. The next event then falls exactly one period later, and software does not have to re-arm it.

Software controls the interrupt enables through separate set and clear registers and acknowledges flags by writing ones. A single interrupt line combines every flag that is enabled. Reads are combinational from the address; a write takes effect at the next rising clock edge.

Top module: `ppct_timer`

## Requirements
- R1: While and after a synchronous active-low reset, every register reads zero and `irq` is low.
- R2: While bit 0 of the control register (offset 0x00) is 1, the prescale counter (0x14) increments every clock. When it equals the prescale limit (0x18) it returns to zero, and the free-running counter (0x10) increments by one in the same clock. While bit 0 is 0, both counters hold.
- R3: The free-running counter wraps from 0xFFFFFFFF to 0, and the compare addition also wraps modulo 2^32.
- R4: When an advance of the free-running counter makes it equal to the compare register (0x50), flag bit 0 becomes 1. In the same clock the compare register becomes its old value plus the step register (0x54).
- R5: Writing to the set-enable register (0x80) sets every enable bit that is 1 in the data. Writing to the clear-enable register (0x84) clears them. Zero data bits leave enables unchanged. Only bits 0–3 and 16–18 exist, other bits read 0, and both offsets read the enable mask.
- R6: Writing to the flag register (0x88) clears every existing flag bit (0–3, 16–18) that is 1 in the data, and zero bits have no effect. If a compare event and a clear of flag bit 0 fall in the same clock, the flag ends up set.
- R7: `irq` is high exactly when some flag bit and the same enable bit are both 1.
- R8: A write to the free-running counter or the prescale counter loads the written value, overriding counting in that clock. A loaded value does not by itself raise a compare event.
- R9: Control bits 0, 1 and 15 are stored and read back, and all other control bits read 0. Bits 1 and 15 do not affect counting. Offsets 0x04, 0x08, 0x0C and unmapped offsets read 0, and writes to them have no effect.
- R10: A software write to the compare register in the same clock as a compare event wins over the step addition.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_addr | input | 8 | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle the assertions check the following:
- Counters hold while counting is disabled.
- The prescale counter restarts after a match.
- Each tick advances the free-running counter by exactly one.
- A compare event adds the step to the compare register.
- A compare event leaves flag 0 set even when a clear arrives in the same clock.
- A write of all zeros to the enable registers changes nothing.

Some behaviours only the bench scenarios can show, because they depend on a sequence of events. These are the exact event period for a given limit and step, wrap-around onto a compare value of zero, and a compare write that lands on the very cycle of an event. The same holds for loaded counter values that must not trigger an event and for the interrupt line following enables that are switched on and off.

// File: rtl/ppct_pkg.sv
// Package: shared constants for the prescaled periodic compare timer.
// Assumes a byte-addressed register port; offsets are fixed by software.
package ppct_pkg;
    localparam int DATA_W = 32;

    localparam int OFF_CTRL  = 'h00;
    localparam int OFF_FRC   = 'h10;
    localparam int OFF_PSC   = 'h14;
    localparam int OFF_LIM   = 'h18;
    localparam int OFF_CMP   = 'h50;
    localparam int OFF_STEP  = 'h54;
    localparam int OFF_IESET = 'h80;
    localparam int OFF_IECLR = 'h84;
    localparam int OFF_FLAG  = 'h88;

    localparam logic [DATA_W-1:0] IRQ_MASK  = 32'h0007_000F;
    localparam logic [DATA_W-1:0] CTRL_MASK = 32'h0000_8003;
    localparam int RUN_BIT = 0;
    localparam int HIT_BIT = 0;

    // Decoded write strobes, one per writable register.
    typedef struct packed {
        logic ctrl;
        logic frc;
        logic psc;
        logic lim;
        logic cmp;
        logic step;
        logic ieset;
        logic ieclr;
        logic flag;
    } wr_strobe_t;
endpackage

// File: rtl/ppct_prescale.sv
// Module: prescale up-counter. Counts every clock while run is high,
// restarts at zero when equal to lim and pulses tick in that clock.
// Assumes ld has priority over counting.
module ppct_prescale #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    input  logic [W-1:0] lim,
    output logic [W-1:0] cnt,
    output logic         tick
);
    logic [W-1:0] cnt_q;

    assign tick = run && (cnt_q == lim);
    assign cnt  = cnt_q;

    // Prescale count: load, restart on match, or advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (ld) begin
            cnt_q <= ld_val;
        end else if (tick) begin
            cnt_q <= '0;
        end else if (run) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !ld) |=> $stable(cnt_q));
    p_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !ld && cnt_q == lim) |=> (cnt_q == '0));
endmodule

// File: rtl/ppct_compare.sv
// Module: free-running counter with compare and step registers.
// A tick advances the counter; an advance landing on the compare value
// raises hit and adds step to compare. Software loads win over hardware.
module ppct_compare #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         frc_ld,
    input  logic         cmp_ld,
    input  logic         step_ld,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] frc,
    output logic [W-1:0] cmp,
    output logic [W-1:0] step,
    output logic         hit
);
    logic [W-1:0] frc_q, cmp_q, step_q;
    logic [W-1:0] frc_inc;

    assign frc_inc = frc_q + 1'b1;
    assign hit     = tick && (frc_inc == cmp_q);
    assign frc     = frc_q;
    assign cmp     = cmp_q;
    assign step    = step_q;

    // Free-running counter: load or advance on tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frc_q <= '0;
        end else if (frc_ld) begin
            frc_q <= wdata;
        end else if (tick) begin
            frc_q <= frc_inc;
        end
    end

    // Compare value: load, or move forward by step on a hit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q <= '0;
        end else if (cmp_ld) begin
            cmp_q <= wdata;
        end else if (hit) begin
            cmp_q <= cmp_q + step_q;
        end
    end

    // Step value: software only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q <= '0;
        end else if (step_ld) begin
            step_q <= wdata;
        end
    end

    p_frc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !frc_ld) |=> (frc_q == $past(frc_q) + 1'b1));
    p_cmp_adv_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !cmp_ld) |=> (cmp_q == $past(cmp_q) + $past(step_q)));
endmodule

// File: rtl/ppct_irq.sv
// Module: interrupt enables, write-one-to-clear flags and request line.
// Only bits in MASK exist; a hardware set beats a software clear.
module ppct_irq #(
    parameter int           W       = 32,
    parameter logic [W-1:0] MASK    = 32'h0007_000F,
    parameter int           HIT_POS = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_we,
    input  logic         clr_we,
    input  logic         flag_we,
    input  logic [W-1:0] wdata,
    input  logic         hit,
    output logic [W-1:0] ie,
    output logic [W-1:0] flags,
    output logic         irq
);
    logic [W-1:0] wsel;
    logic [W-1:0] hw_set;

    assign wsel   = wdata & MASK;
    assign hw_set = W'(hit) << HIT_POS;

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (MASK[i]) begin : g_live
            logic ie_b, fl_b;
            // Enable bit: set register sets, clear register clears.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    ie_b <= 1'b0;
                end else if (set_we && wsel[i]) begin
                    ie_b <= 1'b1;
                end else if (clr_we && wsel[i]) begin
                    ie_b <= 1'b0;
                end
            end
            // Flag bit: hardware set has priority over write-one clear.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    fl_b <= 1'b0;
                end else if (hw_set[i]) begin
                    fl_b <= 1'b1;
                end else if (flag_we && wsel[i]) begin
                    fl_b <= 1'b0;
                end
            end
            assign ie[i]    = ie_b;
            assign flags[i] = fl_b;
        end else begin : g_none
            assign ie[i]    = 1'b0;
            assign flags[i] = 1'b0;
        end
    end

    assign irq = |(flags & ie);

    p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> flags[HIT_POS]);
    p_zero_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((set_we || clr_we) && wsel == '0) |=> $stable(ie));
endmodule

// File: rtl/ppct_timer.sv
// Module: top of the prescaled periodic compare timer. Decodes the
// register port, holds the control register and muxes read data.
// Assumes one access per clock; reads are combinational.
module ppct_timer
    import ppct_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFF_CTRL);
    localparam logic [ADDR_W-1:0] A_FRC   = ADDR_W'(OFF_FRC);
    localparam logic [ADDR_W-1:0] A_PSC   = ADDR_W'(OFF_PSC);
    localparam logic [ADDR_W-1:0] A_LIM   = ADDR_W'(OFF_LIM);
    localparam logic [ADDR_W-1:0] A_CMP   = ADDR_W'(OFF_CMP);
    localparam logic [ADDR_W-1:0] A_STEP  = ADDR_W'(OFF_STEP);
    localparam logic [ADDR_W-1:0] A_IESET = ADDR_W'(OFF_IESET);
    localparam logic [ADDR_W-1:0] A_IECLR = ADDR_W'(OFF_IECLR);
    localparam logic [ADDR_W-1:0] A_FLAG  = ADDR_W'(OFF_FLAG);

    wr_strobe_t        we;
    logic [DATA_W-1:0] ctrl_q, lim_q;
    logic [DATA_W-1:0] psc, frc, cmp, step, ie, flags;
    logic              run, tick, hit;

    // Write decode: one strobe per addressed register.
    always_comb begin
        we.ctrl  = bus_wr && (bus_addr == A_CTRL);
        we.frc   = bus_wr && (bus_addr == A_FRC);
        we.psc   = bus_wr && (bus_addr == A_PSC);
        we.lim   = bus_wr && (bus_addr == A_LIM);
        we.cmp   = bus_wr && (bus_addr == A_CMP);
        we.step  = bus_wr && (bus_addr == A_STEP);
        we.ieset = bus_wr && (bus_addr == A_IESET);
        we.ieclr = bus_wr && (bus_addr == A_IECLR);
        we.flag  = bus_wr && (bus_addr == A_FLAG);
    end

    // Control register: keeps only the defined bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (we.ctrl) begin
            ctrl_q <= bus_wdata & CTRL_MASK;
        end
    end

    // Prescale limit register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lim_q <= '0;
        end else if (we.lim) begin
            lim_q <= bus_wdata;
        end
    end

    assign run = ctrl_q[RUN_BIT];

    ppct_prescale #(.W(DATA_W)) u_psc (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .ld     (we.psc),
        .ld_val (bus_wdata),
        .lim    (lim_q),
        .cnt    (psc),
        .tick   (tick)
    );

    ppct_compare #(.W(DATA_W)) u_cmp (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .frc_ld  (we.frc),
        .cmp_ld  (we.cmp),
        .step_ld (we.step),
        .wdata   (bus_wdata),
        .frc     (frc),
        .cmp     (cmp),
        .step    (step),
        .hit     (hit)
    );

    ppct_irq #(.W(DATA_W), .MASK(IRQ_MASK), .HIT_POS(HIT_BIT)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_we  (we.ieset),
        .clr_we  (we.ieclr),
        .flag_we (we.flag),
        .wdata   (bus_wdata),
        .hit     (hit),
        .ie      (ie),
        .flags   (flags),
        .irq     (irq)
    );

    // Read mux: unmapped offsets return zero.
    always_comb begin
        unique case (bus_addr)
            A_CTRL:          bus_rdata = ctrl_q;
            A_FRC:           bus_rdata = frc;
            A_PSC:           bus_rdata = psc;
            A_LIM:           bus_rdata = lim_q;
            A_CMP:           bus_rdata = cmp;
            A_STEP:          bus_rdata = step;
            A_IESET, A_IECLR: bus_rdata = ie;
            A_FLAG:          bus_rdata = flags;
            default:         bus_rdata = '0;
        endcase
    end

    p_stopped_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !we.frc) |=> $stable(frc));
endmodule

// File: tb/tb_ppct_timer.sv
// Bench: behavioural reference model updated every rising edge and
// compared with read data and irq at every falling edge.
module tb_ppct_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        irq;

    int    n_cmp = 0;
    int    n_bad = 0;
    string tag = "R1";

    always #2 clk = ~clk;

    ppct_timer dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    // Reference state
    logic [31:0] m_ctrl, m_psc, m_lim, m_frc, m_cmp, m_step, m_ie, m_fl;
    localparam logic [31:0] EMASK = 32'h0007_000F;

    always @(posedge clk) begin
        logic tk, ht;
        logic [31:0] fn, pn, cn, ien, fln;
        if (!rst_n) begin
            m_ctrl = 0; m_psc = 0; m_lim = 0; m_frc = 0;
            m_cmp = 0; m_step = 0; m_ie = 0; m_fl = 0;
        end else begin
            tk = m_ctrl[0] && (m_psc == m_lim);
            ht = tk && (m_frc + 32'd1 == m_cmp);
            pn = m_ctrl[0] ? (tk ? 32'd0 : m_psc + 32'd1) : m_psc;
            fn = tk ? m_frc + 32'd1 : m_frc;
            cn = ht ? m_cmp + m_step : m_cmp;
            ien = m_ie; fln = m_fl;
            if (bus_wr) begin
                case (bus_addr)
                    8'h00: m_ctrl = bus_wdata & 32'h0000_8003;
                    8'h10: fn = bus_wdata;
                    8'h14: pn = bus_wdata;
                    8'h18: m_lim = bus_wdata;
                    8'h50: cn = bus_wdata;
                    8'h54: m_step = bus_wdata;
                    8'h80: ien = ien | (bus_wdata & EMASK);
                    8'h84: ien = ien & ~(bus_wdata & EMASK);
                    8'h88: fln = fln & ~(bus_wdata & EMASK);
                    default: ;
                endcase
            end
            if (ht) fln[0] = 1'b1;
            m_psc = pn; m_frc = fn; m_cmp = cn; m_ie = ien; m_fl = fln;
        end
    end

    function automatic logic [31:0] m_read(input logic [7:0] a);
        case (a)
            8'h00: return m_ctrl;
            8'h10: return m_frc;
            8'h14: return m_psc;
            8'h18: return m_lim;
            8'h50: return m_cmp;
            8'h54: return m_step;
            8'h80, 8'h84: return m_ie;
            8'h88: return m_fl;
            default: return 32'h0;
        endcase
    endfunction

    task automatic compare();
        logic [31:0] e;
        logic ei;
        e  = m_read(bus_addr);
        ei = |(m_fl & m_ie);
        n_cmp += 2;
        if (bus_rdata !== e) begin
            n_bad++;
            $display("FAIL %s addr=%h rdata actual=%h expected=%h", tag, bus_addr, bus_rdata, e);
        end
        if (irq !== ei) begin
            n_bad++;
            $display("FAIL %s/R7 irq actual=%b expected=%b", tag, irq, ei);
        end
    endtask

    // One clock: compare current state, then drive the next access.
    task automatic cyc(input logic w, input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        compare();
        bus_wr = w; bus_addr = a; bus_wdata = d;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        cyc(1'b1, a, d);
    endtask

    task automatic idle(input logic [7:0] a, input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, a, 32'h0);
    endtask

    initial begin
        #(4 * 200000);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // R1: reset state on every register
        tag = "R1";
        repeat (3) @(posedge clk);
        foreach (bus_addr[i]) ;
        idle(8'h00, 1); idle(8'h10, 1); idle(8'h14, 1); idle(8'h50, 1);
        @(negedge clk); rst_n = 1'b1;
        idle(8'h88, 1); idle(8'h80, 1); idle(8'h54, 1); idle(8'h18, 1);

        // R5: set/clear enables, zero writes, unimplemented bits
        tag = "R5";
        wr(8'h80, 32'hFFFF_FFFF); idle(8'h80, 1);
        wr(8'h84, 32'h0000_0002); idle(8'h84, 1);
        wr(8'h80, 32'h0); idle(8'h80, 1);
        wr(8'h84, 32'h0); idle(8'h84, 1);
        wr(8'h84, 32'hFFFF_FFFF); wr(8'h80, 32'h1); idle(8'h80, 1);

        // R9: bits 1 and 15 stored but no counting; reserved offsets
        tag = "R9";
        wr(8'h00, 32'hFFFF_FFFE); idle(8'h00, 2);
        idle(8'h14, 4); idle(8'h10, 2);
        wr(8'h04, 32'hFFFF_FFFF); wr(8'h08, 32'h1234); wr(8'h0C, 32'h55);
        idle(8'h04, 1); idle(8'h08, 1); idle(8'h0C, 1); idle(8'h3C, 1);

        // R2/R4/R7: prescale limit 3, compare 5, step 5
        tag = "R2";
        wr(8'h18, 32'd3); wr(8'h50, 32'd5); wr(8'h54, 32'd5);
        wr(8'h00, 32'h1);
        idle(8'h14, 10);
        idle(8'h10, 30);
        tag = "R4";
        idle(8'h50, 20); idle(8'h88, 8);

        // R6: zero write then w1c, clears hammering across an event
        tag = "R6";
        wr(8'h88, 32'h0); idle(8'h88, 1);
        wr(8'h88, 32'h1); idle(8'h88, 1);
        for (int i = 0; i < 45; i++) wr(8'h88, 32'hFFFF_FFFF);
        idle(8'h88, 25);
        wr(8'h88, 32'h1); idle(8'h88, 2);

        // R7: irq gated by enable
        tag = "R7";
        idle(8'h88, 25);
        wr(8'h84, 32'h1); idle(8'h88, 2);
        wr(8'h80, 32'h1); idle(8'h88, 2);
        wr(8'h88, 32'h1);

        // R8/R3: stopped loads, wrap onto compare 0
        tag = "R8";
        wr(8'h00, 32'h0);
        wr(8'h10, 32'hFFFF_FFFC); wr(8'h14, 32'd0);
        wr(8'h18, 32'd0); wr(8'h50, 32'hFFFF_FFFC); wr(8'h54, 32'd2);
        idle(8'h10, 2); idle(8'h14, 1); idle(8'h88, 2);
        tag = "R3";
        wr(8'h50, 32'h0000_0000);
        wr(8'h00, 32'h1);
        idle(8'h10, 6); idle(8'h50, 2); idle(8'h88, 1);
        wr(8'h88, 32'h1);
        wr(8'h50, 32'hFFFF_FFFF); wr(8'h54, 32'd3);
        wr(8'h10, 32'hFFFF_FFFA);
        idle(8'h50, 8); idle(8'h10, 2);
        tag = "R8";
        wr(8'h14, 32'd0); wr(8'h10, 32'd100); idle(8'h10, 3);

        // R10: compare write on the cycle of an event
        tag = "R10";
        wr(8'h54, 32'd1);
        wr(8'h50, 32'd120);
        for (int i = 0; i < 20; i++) wr(8'h50, 32'd120);
        idle(8'h50, 3); idle(8'h88, 2);

        // R2: counting stops when bit 0 drops
        tag = "R2";
        wr(8'h00, 32'h8002); idle(8'h10, 4); idle(8'h14, 3);

        @(negedge clk);
        compare();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule